// File: doc/BRIEF.md
# UART Receive FIFO Status and Interrupt Unit

This block sits between the receive/transmit datapath of a UART and the host register interface. It holds received characters in a small FIFO. Each entry carries its own three error tags: parity, framing and break. From this state the block produces the eight-bit line status byte and a single interrupt line. The host pops the head character through a read strobe. It clears the sticky overrun flag by reading the status byte.

Two receive behaviours are selectable. When the FIFO is enabled, the full depth is used and the receive interrupt follows a programmable trigger level in both directions. When the FIFO is disabled, the block acts as a single holding position with an implied trigger of one. Interrupts are masked per source. With all enables cleared, the block runs in polled mode: the host reads only the status byte, and the receive and transmit indications stay usable independently.

Top module: `uart_fifo_stat`

## Requirements
- R1: Status bit 0 (data ready) is 1 from the cycle after a character is accepted into the receive FIFO. It returns to 0 only when the FIFO becomes empty, and it never drops while no pop is requested.
- R2: Status bit 1 (overrun) is set when a character arrives while the FIFO is at capacity and no pop happens in the same cycle. Capacity is DEPTH entries with the FIFO enabled and 1 entry with it disabled. The arriving character is discarded and the FIFO is left unchanged. A status read strobe clears the bit the next cycle, and a new overrun in the same cycle wins over the clear.
- R3: Status bits 2, 3 and 4 show the parity (rx_err[0]), framing (rx_err[1]) and break (rx_err[2]) tags of the head entry only. They are 0 when the FIFO is empty.
- R4: Status bit 5 equals the transmit-FIFO-empty input. Status bit 6 is 1 only when both the transmit FIFO and the transmit shift register are empty.
- R5: Status bit 7 is 1 while at least one stored entry carries a nonzero error tag, and 0 otherwise.
- R6: The trigger level is held in a register that is loaded on trig_wr. Encoding 00 gives 1 entry, 01 gives 4, 10 gives 8 and 11 gives 14. Reset selects 00.
- R7: The interrupt output is registered. With int_en[0] set, irq is 1 in the cycle after the stored count is at or above the trigger level, and 0 in the cycle after it falls below. With the FIFO disabled, the level is 1.
- R8: With int_en[1] set, the transmit source is active while tx_fifo_empty is 1. irq_id reports 2'b10 for receive, 2'b01 for transmit and 2'b00 for none. Receive has priority over transmit.
- R9: With int_en all zero (polled mode), irq stays 0 while the status byte keeps tracking receive and transmit state.
- R10: After reset the FIFO is empty, all error tags and overrun are clear, and irq and irq_id are 0. Status bits 5 and 6 follow the transmit inputs.
- R11: rx_head shows the data of the head entry and is 0 when the FIFO is empty. A pop request on an empty FIFO has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_en | input | 1 | 1 = full-depth FIFO, 0 = single holding position |
| rx_push | input | 1 | A received character is presented this cycle |
| rx_data | input | 8 | Received character |
| rx_err | input | 3 | Error tags of the character: [0] parity, [1] framing, [2] break |
| host_rd_data | input | 1 | Host reads (pops) the head character |
| host_rd_stat | input | 1 | Host reads the status byte (clears overrun) |
| tx_fifo_empty | input | 1 | Transmit FIFO / holding position is empty |
| tx_shift_empty | input | 1 | Transmit shift register is empty |
| int_en | input | 2 | Interrupt enables: [0] receive data, [1] transmit empty |
| trig_wr | input | 1 | Load the trigger selection |
| trig_sel | input | 2 | Trigger level code |
| rx_head | output | 8 | Head character, 0 when empty |
| line_stat | output | 8 | Status byte |
| irq | output | 1 | Interrupt request |
| irq_id | output | 2 | Highest-priority active source |

## Verification
A wrong count or pointer shows at the ports as soon as the status byte next samples the FIFO. It appears as data ready dropping early, a stale head character, or an interrupt edge one entry off the trigger. A lost or doubled error tag changes the head error bits when that entry reaches the head. It changes the summary bit at once, because that bit must clear exactly when the last tagged entry leaves. An overrun that corrupts the FIFO shows as a wrong head character when the FIFO drains. The reference model is compared every cycle, so each of these faults is reported within one clock of reaching the ports.

// File: rtl/uart_stat_pkg.sv
// Package: shared widths and trigger-level decode for the UART status unit.
// Assumes the FIFO depth is at least 14 so that every trigger level fits.
package uart_stat_pkg;

    localparam int unsigned DATA_W = 8;
    localparam int unsigned TAG_W  = 3;

    // Error tag bit positions inside an entry tag
    localparam int unsigned TAG_PAR = 0;
    localparam int unsigned TAG_FRM = 1;
    localparam int unsigned TAG_BRK = 2;

    typedef enum logic [1:0] {
        IRQ_NONE = 2'b00,
        IRQ_TX   = 2'b01,
        IRQ_RX   = 2'b10
    } irq_src_e;

    // Decode the two-bit trigger code into an entry count
    function automatic int unsigned trig_level(input logic [1:0] code);
        case (code)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/ust_rx_fifo.sv
// Module: receive FIFO with one error tag per entry.
// It tracks occupancy, the count of tagged entries and the sticky overrun flag.
// Assumes push and pop are single-cycle strobes. The capacity drops to one
// entry when fifo_en is low.
module ust_rx_fifo #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned DW    = 8,
    parameter int unsigned TW    = 3,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic [TW-1:0] tin,
    input  logic          pop,
    input  logic          stat_rd,
    output logic [CW-1:0] count,
    output logic [DW-1:0] head_d,
    output logic [TW-1:0] head_t,
    output logic          err_any,
    output logic          ovr
);

    logic [DW-1:0] dmem [DEPTH];
    logic [TW-1:0] tmem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] err_cnt;
    logic [CW-1:0] cap;
    logic          full, pop_ok, push_ok, ovr_set;

    // Capacity, acceptance and overrun decisions
    always_comb begin
        cap     = fifo_en ? CW'(DEPTH) : CW'(1);
        full    = (count >= cap);
        pop_ok  = pop && (count != '0);
        push_ok = push && (!full || pop_ok);
        ovr_set = push && full && !pop_ok;
    end

    // Entry storage written on accepted pushes
    always_ff @(posedge clk) begin
        if (push_ok) begin
            dmem[wr_ptr] <= din;
            tmem[wr_ptr] <= tin;
        end
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok)
                wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)
                rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(push_ok) - CW'(pop_ok);
        end
    end

    // Count of stored entries that carry any error
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_cnt <= '0;
        else
            err_cnt <= err_cnt + CW'(push_ok && (tin != '0))
                               - CW'(pop_ok && (head_t != '0));
    end

    // Sticky overrun: a new overrun wins over a status read clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovr <= 1'b0;
        else if (ovr_set)
            ovr <= 1'b1;
        else if (stat_rd)
            ovr <= 1'b0;
    end

    // Head view, zeroed while empty
    always_comb begin
        head_d  = (count != '0) ? dmem[rd_ptr] : '0;
        head_t  = (count != '0) ? tmem[rd_ptr] : '0;
        err_any = (err_cnt != '0);
    end

endmodule

// File: rtl/ust_irq_gen.sv
// Module: trigger-level register and registered interrupt generation.
// The receive source follows the trigger level in both directions.
// Receive has priority over transmit in the reported source.
// Assumes count is the registered FIFO occupancy.
module ust_irq_gen
    import uart_stat_pkg::*;
#(
    parameter int unsigned CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic [CW-1:0] count,
    input  logic          trig_wr,
    input  logic [1:0]    trig_sel,
    input  logic [1:0]    int_en,
    input  logic          tx_fifo_empty,
    output logic          irq,
    output logic [1:0]    irq_id
);

    logic [1:0]    trig_q;
    logic [CW-1:0] level;
    logic          rx_src, tx_src;
    irq_src_e      src_nxt;

    // Trigger selection register, reset to the one-entry level
    always_ff @(posedge clk) begin
        if (!rst_n)
            trig_q <= 2'b00;
        else if (trig_wr)
            trig_q <= trig_sel;
    end

    // Source evaluation and priority selection
    always_comb begin
        level  = fifo_en ? CW'(trig_level(trig_q)) : CW'(1);
        rx_src = int_en[0] && (count >= level);
        tx_src = int_en[1] && tx_fifo_empty;
        if (rx_src)
            src_nxt = IRQ_RX;
        else if (tx_src)
            src_nxt = IRQ_TX;
        else
            src_nxt = IRQ_NONE;
    end

    // Registered interrupt outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq    <= 1'b0;
            irq_id <= IRQ_NONE;
        end else begin
            irq    <= rx_src || tx_src;
            irq_id <= src_nxt;
        end
    end

endmodule

// File: rtl/uart_fifo_stat.sv
// Module: top of the UART receive FIFO status and interrupt unit.
// It assembles the status byte from the FIFO state and the transmit flags.
// Assumes the host strobes are single-cycle. The status byte is combinational
// from registered state and the transmit inputs.
module uart_fifo_stat
    import uart_stat_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_data,
    input  logic [TAG_W-1:0]  rx_err,
    input  logic              host_rd_data,
    input  logic              host_rd_stat,
    input  logic              tx_fifo_empty,
    input  logic              tx_shift_empty,
    input  logic [1:0]        int_en,
    input  logic              trig_wr,
    input  logic [1:0]        trig_sel,
    output logic [DATA_W-1:0] rx_head,
    output logic [7:0]        line_stat,
    output logic              irq,
    output logic [1:0]        irq_id
);

    logic [CW-1:0]    count;
    logic [TAG_W-1:0] head_t;
    logic             err_any, ovr;

    ust_rx_fifo #(.DEPTH(DEPTH), .DW(DATA_W), .TW(TAG_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .fifo_en (fifo_en),
        .push    (rx_push),
        .din     (rx_data),
        .tin     (rx_err),
        .pop     (host_rd_data),
        .stat_rd (host_rd_stat),
        .count   (count),
        .head_d  (rx_head),
        .head_t  (head_t),
        .err_any (err_any),
        .ovr     (ovr)
    );

    ust_irq_gen #(.CW(CW)) u_irq (
        .clk           (clk),
        .rst_n         (rst_n),
        .fifo_en       (fifo_en),
        .count         (count),
        .trig_wr       (trig_wr),
        .trig_sel      (trig_sel),
        .int_en        (int_en),
        .tx_fifo_empty (tx_fifo_empty),
        .irq           (irq),
        .irq_id        (irq_id)
    );

    // Status byte assembly
    always_comb begin
        line_stat[0] = (count != '0);
        line_stat[1] = ovr;
        line_stat[2] = head_t[TAG_PAR];
        line_stat[3] = head_t[TAG_FRM];
        line_stat[4] = head_t[TAG_BRK];
        line_stat[5] = tx_fifo_empty;
        line_stat[6] = tx_fifo_empty && tx_shift_empty;
        line_stat[7] = err_any;
    end

endmodule

// File: rtl/ust_chk.sv
// Module: assertion checker for uart_fifo_stat, attached with bind.
module ust_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_rd_data,
    input logic       host_rd_stat,
    input logic       rx_push,
    input logic [1:0] int_en,
    input logic [7:0] rx_head,
    input logic [7:0] line_stat,
    input logic       irq,
    input logic [1:0] irq_id
);

    // R1
    dr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_stat[0] && !host_rd_data |=> line_stat[0]);

    // R2
    ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd_stat && !rx_push |=> !line_stat[1]);

    // R3
    head_err_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_stat[0] |-> (line_stat[4:2] == 3'b000));

    // R4
    temt_implies_thre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_stat[6] |-> line_stat[5]);

    // R5
    err_sum_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_stat[0] |-> !line_stat[7]);

    // R8
    irq_id_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq_id) && (irq == (irq_id != 2'b00)));

    // R9
    polled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_en == 2'b00) |=> !irq);

    // R11
    head_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !line_stat[0] |-> (rx_head == 8'h00));

endmodule

bind uart_fifo_stat ust_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_rd_data (host_rd_data),
    .host_rd_stat (host_rd_stat),
    .rx_push      (rx_push),
    .int_en       (int_en),
    .rx_head      (rx_head),
    .line_stat    (line_stat),
    .irq          (irq),
    .irq_id       (irq_id)
);

// File: tb/uart_fifo_stat_tb_top.sv
// Bench: behavioural reference model (queue based) compared every clock.
module uart_fifo_stat_tb_top;

    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b1;
    logic       rx_push = 1'b0;
    logic [7:0] rx_data = '0;
    logic [2:0] rx_err = '0;
    logic       host_rd_data = 1'b0;
    logic       host_rd_stat = 1'b0;
    logic       tx_fifo_empty = 1'b1;
    logic       tx_shift_empty = 1'b1;
    logic [1:0] int_en = 2'b00;
    logic       trig_wr = 1'b0;
    logic [1:0] trig_sel = 2'b00;
    logic [7:0] rx_head;
    logic [7:0] line_stat;
    logic       irq;
    logic [1:0] irq_id;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    uart_fifo_stat #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .rx_push(rx_push),
        .rx_data(rx_data), .rx_err(rx_err), .host_rd_data(host_rd_data),
        .host_rd_stat(host_rd_stat), .tx_fifo_empty(tx_fifo_empty),
        .tx_shift_empty(tx_shift_empty), .int_en(int_en), .trig_wr(trig_wr),
        .trig_sel(trig_sel), .rx_head(rx_head), .line_stat(line_stat),
        .irq(irq), .irq_id(irq_id)
    );

    // Reference model state
    logic [10:0] mq[$];   // {tag[2:0], data[7:0]}
    bit          m_ovr = 0;
    int          m_trig = 1;
    bit          m_irq = 0;
    logic [1:0]  m_id = 2'b00;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Model update at each edge, then comparison 3 ns later
    always @(posedge clk) begin
        int  cnt, cap, trg;
        bit  rxi, txi, pop_ok, anyerr;
        logic [2:0] ht;
        logic [7:0] hd;
        if (!rst_n) begin
            mq.delete(); m_ovr = 0; m_trig = 1; m_irq = 0; m_id = 2'b00;
        end else begin
            cnt = mq.size();
            cap = fifo_en ? DEPTH : 1;
            trg = fifo_en ? m_trig : 1;
            rxi = int_en[0] && (cnt >= trg);
            txi = int_en[1] && tx_fifo_empty;
            m_irq = rxi || txi;
            m_id  = rxi ? 2'b10 : (txi ? 2'b01 : 2'b00);
            pop_ok = host_rd_data && (cnt > 0);
            if (host_rd_stat) m_ovr = 0;
            if (rx_push && !(cnt < cap || pop_ok)) m_ovr = 1;
            if (pop_ok) void'(mq.pop_front());
            if (rx_push && (cnt < cap || pop_ok)) mq.push_back({rx_err, rx_data});
            if (trig_wr)
                m_trig = (trig_sel == 2'b00) ? 1 : (trig_sel == 2'b01) ? 4 :
                         (trig_sel == 2'b10) ? 8 : 14;
        end
        #3;
        if (!done) begin
            anyerr = 0;
            foreach (mq[i]) if (mq[i][10:8] != 3'b000) anyerr = 1;
            ht = (mq.size() > 0) ? mq[0][10:8] : 3'b000;
            hd = (mq.size() > 0) ? mq[0][7:0] : 8'h00;
            chk(line_stat[0] == (mq.size() > 0), "R1 data ready", line_stat[0], mq.size() > 0);
            chk(line_stat[1] == m_ovr, "R2 overrun", line_stat[1], m_ovr);
            chk(line_stat[4:2] == ht, "R3 head errors", line_stat[4:2], ht);
            chk(line_stat[6:5] == {tx_fifo_empty && tx_shift_empty, tx_fifo_empty},
                "R4 tx empty bits", line_stat[6:5], {tx_fifo_empty && tx_shift_empty, tx_fifo_empty});
            chk(line_stat[7] == anyerr, "R5 error summary", line_stat[7], anyerr);
            chk(irq == m_irq, "R7 irq", irq, m_irq);
            chk(irq_id == m_id, "R8 irq_id", irq_id, m_id);
            chk(rx_head == hd, "R11 head data", rx_head, hd);
        end
    end

    // One cycle of stimulus, applied at the falling edge
    task automatic cyc(input bit push, input logic [7:0] d, input logic [2:0] e,
                       input bit rd, input bit srd);
        @(negedge clk);
        rx_push = push; rx_data = d; rx_err = e;
        host_rd_data = rd; host_rd_stat = srd; trig_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 8'h00, 3'b000, 0, 0);
    endtask

    task automatic set_trig(input logic [1:0] s);
        @(negedge clk);
        rx_push = 0; host_rd_data = 0; host_rd_stat = 0;
        trig_wr = 1'b1; trig_sel = s;
    endtask

    // Watchdog
    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        // R10: reset state seen at the ports
        #1 chk(line_stat == 8'h60 && irq == 0 && irq_id == 2'b00 && rx_head == 0,
               "R10 reset state", line_stat, 8'h60);

        // R1 R3 R5 R11: tagged and clean characters, then drain
        cyc(1, 8'hA1, 3'b000, 0, 0);
        cyc(1, 8'hB2, 3'b001, 0, 0);
        cyc(1, 8'hC3, 3'b110, 0, 0);
        idle(2);
        for (int i = 0; i < 4; i++) cyc(0, 8'h00, 3'b000, 1, 0);  // last pop hits empty
        idle(2);

        // R6 R7: trigger 4 with the receive interrupt enabled
        int_en = 2'b01;
        set_trig(2'b01);
        for (int i = 0; i < 5; i++) cyc(1, 8'(8'h10 + i), 3'b000, 0, 0);
        idle(2);
        for (int i = 0; i < 3; i++) cyc(0, 8'h00, 3'b000, 1, 0);
        idle(2);
        // R7: trigger 8 with count below it, then fill to it
        set_trig(2'b10);
        idle(2);
        for (int i = 0; i < 6; i++) cyc(1, 8'(8'h20 + i), 3'b100, 0, 0);
        idle(2);

        // R2: fill to capacity, overrun, set wins over a clear
        set_trig(2'b11);
        for (int i = 0; i < 10; i++) cyc(1, 8'(8'h40 + i), 3'b000, 0, 0);
        cyc(1, 8'hEE, 3'b010, 0, 0);
        cyc(1, 8'hEF, 3'b010, 0, 1);
        idle(1);
        cyc(0, 8'h00, 3'b000, 0, 1);
        cyc(1, 8'h77, 3'b000, 1, 0);   // push with pop while full is accepted
        idle(2);

        // R8: both sources, then transmit alone, priority checked
        int_en = 2'b11;
        tx_fifo_empty = 1'b1; tx_shift_empty = 1'b0;
        idle(2);
        for (int i = 0; i < DEPTH; i++) cyc(0, 8'h00, 3'b000, 1, 0);
        idle(2);
        tx_fifo_empty = 1'b0;
        idle(2);
        int_en = 2'b10; tx_fifo_empty = 1'b1; tx_shift_empty = 1'b1;
        idle(2);

        // R9: polled mode with data above trigger and transmit empty
        int_en = 2'b00;
        set_trig(2'b00);
        for (int i = 0; i < 3; i++) cyc(1, 8'(8'h60 + i), 3'b001, 0, 0);
        idle(2);
        #1 chk(irq == 1'b0, "R9 polled no irq", irq, 0);
        for (int i = 0; i < 3; i++) cyc(0, 8'h00, 3'b000, 1, 0);
        idle(1);

        // R2 R7: FIFO disabled acts as one holding position
        fifo_en = 1'b0; int_en = 2'b01;
        set_trig(2'b11);
        cyc(1, 8'h91, 3'b000, 0, 0);
        cyc(1, 8'h92, 3'b000, 0, 0);
        idle(2);
        cyc(0, 8'h00, 3'b000, 1, 1);
        idle(3);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule